// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer. It divides a fast input clock by N = B·P + A. A prescaler divides by either P or P+1. Its modulus comes from a 2-bit select and the choices are 8/9, 16/17, 32/33 or 64/65. The prescaler is built as a divide-by-4/5 core with an upper quarter counter. Two counters set the modulus in each output period:

- A main counter counts B prescaler cycles.
- A swallow counter holds the prescaler at P+1 for the first A of those cycles.

With this split, every integer N at or above P² − P can be reached. Once every N input clocks the block emits a one-cycle pulse towards the phase detector.

A new modulus select, B and A are presented together with a one-cycle load strobe. While the divider is counting, the strobe only stages the values. They are adopted at the next output-period boundary, so a period in flight is never disturbed. When the divider is idle, the strobe writes the values directly into the active setting. An active setting is invalid when any of these holds:

- B is below 3.
- A exceeds B.
- B·P + A falls below P² − P.

An invalid active setting raises a flag and keeps the output quiet until a legal setting is loaded.

The prescaler state machine has five states:

- PS_C0 → PS_C1 → PS_C2 → PS_C3 is the divide-by-4 walk.
- PS_C3 → PS_C0 is taken unless this is the last quarter and the modulus control is high.
- In that case PS_C3 → PS_SW inserts the single swallowed clock, and PS_SW → PS_C0 follows.

The period controller has three states:

- CT_IDLE → CT_SWALLOW or CT_MAIN on start, when the active setting is legal and nothing is staged or being loaded.
- CT_SWALLOW → CT_MAIN when the swallow counter expires.
- CT_SWALLOW/CT_MAIN → CT_SWALLOW/CT_MAIN on reload at a period boundary.
- CT_SWALLOW/CT_MAIN → CT_IDLE at a boundary whose next setting is invalid.

Top module: `swallow_fb_divider`

## Requirements
- R1: With a legal setting, consecutive rising pulses of `div_out` are exactly B·P + A input clocks apart. When the divider starts from idle, the first pulse appears N+2 cycles after the cycle in which the load strobe was high.
- R2: `psel` chooses the prescaler base modulus: 0 gives P=8, 1 gives P=16, 2 gives P=32, 3 gives P=64.
- R3: `b_val` is a 13-bit binary count. A value of B below 3 makes the setting invalid.
- R4: A setting with A greater than B is invalid. While an invalid setting is active, `cfg_bad` is 1 and `div_out` stays 0.
- R5: A setting is invalid when B·P + A < P² − P. N equal to P² − P is legal.
- R6: With A = 0, the period is B·P clocks, because the prescaler uses modulus P for the whole period.
- R7: A load while the divider is counting leaves the period in progress unchanged. The new setting governs the very next period. The newest staged setting wins.
- R8: `div_out` is never high for two consecutive cycles.
- R9: After a synchronous reset, `div_out` is 0 and `cfg_bad` is 1, because the reset setting is all zero. A load while idle writes the active setting directly.
- R10: When a period ends and the next setting is invalid, that final pulse is still issued. The output then goes quiet and `cfg_bad` rises in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 2 | Prescaler modulus select (8, 16, 32, 64) |
| b_val | input | 13 | Main counter preset B |
| a_val | input | 6 | Swallow counter preset A |
| load | input | 1 | One-cycle strobe that captures psel, b_val and a_val |
| div_out | output | 1 | One-cycle pulse once every N input clocks |
| cfg_bad | output | 1 | Active setting is invalid; output held quiet |

## Verification
The embedded assertions check the following on every cycle:
- Pulses last exactly one cycle.
- The prescaler never ticks twice in a row.
- The active setting stays frozen while a period is in progress.
- The swallow count never exceeds the remaining main count.
- The divider is never running on a setting flagged invalid.
- The idle state never produces a pulse.

Only the bench scenarios can show the remaining behaviour. They establish that the pulse spacing equals B·P + A for each modulus and for random legal settings. They also show that the P² − P bound is exact, that a mid-period load is deferred by precisely one period, and that a boundary into an invalid setting emits its last pulse and then falls silent. Each of these is compared against a behavioural cycle model.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

    localparam int SWD_SEL_W = 2;
    localparam int SWD_B_W   = 13;
    localparam int SWD_A_W   = 6;
    localparam int SWD_HI_W  = 4;
    localparam int SWD_N_W   = SWD_B_W + 7;

    typedef struct packed {
        logic [SWD_SEL_W-1:0] sel;
        logic [SWD_B_W-1:0]   b;
        logic [SWD_A_W-1:0]   a;
    } swdiv_cfg_t;

    typedef enum logic [2:0] {
        PS_C0,
        PS_C1,
        PS_C2,
        PS_C3,
        PS_SW
    } ps_state_t;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_SWALLOW,
        CT_MAIN
    } ct_state_t;

    // Last value of the quarter counter for modulus P: P/4 - 1.
    function automatic logic [SWD_HI_W-1:0] quarter_last(input logic [SWD_SEL_W-1:0] sel);
        logic [SWD_HI_W-1:0] r;
        unique case (sel)
            2'd0:    r = 4'd1;
            2'd1:    r = 4'd3;
            2'd2:    r = 4'd7;
            default: r = 4'd15;
        endcase
        return r;
    endfunction

    // Base modulus P for a select value.
    function automatic logic [SWD_N_W-1:0] base_modulus(input logic [SWD_SEL_W-1:0] sel);
        return SWD_N_W'(8) << sel;
    endfunction

endpackage

// File: rtl/swdiv_cfg_check.sv
module swdiv_cfg_check
    import swdiv_pkg::*;
(
    input  swdiv_cfg_t cfg,
    output logic       bad
);
    logic [SWD_N_W-1:0] p_val;
    logic [SWD_N_W-1:0] n_val;
    logic [SWD_N_W-1:0] n_min;
    logic               b_small;
    logic               a_over;
    logic               n_short;

    always_comb begin
        p_val   = base_modulus(cfg.sel);
        n_val   = SWD_N_W'(cfg.b) * p_val + SWD_N_W'(cfg.a);
        n_min   = p_val * p_val - p_val;
        b_small = (cfg.b < SWD_B_W'(3));
        a_over  = (SWD_B_W'(cfg.a) > cfg.b);
        n_short = (n_val < n_min);
        bad     = b_small | a_over | n_short;
    end
endmodule

// File: rtl/swdiv_cfg_regs.sv
module swdiv_cfg_regs
    import swdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  swdiv_cfg_t in_cfg,
    input  logic       idle,
    input  logic       boundary,
    output swdiv_cfg_t act_cfg,
    output swdiv_cfg_t nxt_cfg,
    output logic       busy
);
    swdiv_cfg_t act_q;
    swdiv_cfg_t pend_q;
    logic       pflag_q;
    logic       consume;

    always_comb begin
        consume = pflag_q & (idle | boundary);
        nxt_cfg = pflag_q ? pend_q : act_q;
        act_cfg = act_q;
        busy    = load | pflag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            pend_q  <= '0;
            pflag_q <= 1'b0;
        end else if (idle) begin
            if (load) begin
                act_q   <= in_cfg;
                pflag_q <= 1'b0;
            end else if (pflag_q) begin
                act_q   <= pend_q;
                pflag_q <= 1'b0;
            end
        end else begin
            if (consume) begin
                act_q <= pend_q;
            end
            if (load) begin
                pend_q  <= in_cfg;
                pflag_q <= 1'b1;
            end else if (consume) begin
                pflag_q <= 1'b0;
            end
        end
    end

    // Active setting only moves at a boundary while counting.
    assert_act_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (!idle && !boundary) |=> $stable(act_q));
endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
    import swdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [SWD_SEL_W-1:0] sel,
    input  logic                 mod,
    output logic                 tick
);
    ps_state_t           state_q, state_d;
    logic [SWD_HI_W-1:0] hi_q, hi_d;
    logic [SWD_HI_W-1:0] hi_last;
    logic                last_quarter;

    always_comb begin
        hi_last      = quarter_last(sel);
        last_quarter = (hi_q == hi_last);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state_q <= PS_C0;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            hi_q    <= hi_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        hi_d    = hi_q;
        unique case (state_q)
            PS_C0: state_d = PS_C1;
            PS_C1: state_d = PS_C2;
            PS_C2: state_d = PS_C3;
            PS_C3: begin
                if (!last_quarter) begin
                    state_d = PS_C0;
                    hi_d    = hi_q + 1'b1;
                end else if (mod) begin
                    state_d = PS_SW;
                end else begin
                    state_d = PS_C0;
                    hi_d    = '0;
                end
            end
            PS_SW: begin
                state_d = PS_C0;
                hi_d    = '0;
            end
            default: begin
                state_d = PS_C0;
                hi_d    = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        tick = run & (((state_q == PS_C3) & last_quarter & ~mod) | (state_q == PS_SW));
    end

    assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/swdiv_count_ctrl.sv
module swdiv_count_ctrl
    import swdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  swdiv_cfg_t nxt_cfg,
    input  logic       nxt_bad,
    input  logic       cfg_busy,
    output logic       run,
    output logic       mod,
    output logic       idle,
    output logic       boundary,
    output logic       div_out
);
    ct_state_t          state_q, state_d;
    logic [SWD_B_W-1:0] bcnt_q, bcnt_d;
    logic [SWD_A_W-1:0] acnt_q, acnt_d;
    logic               start;
    logic               period_end;
    logic               div_q;

    always_comb begin
        start      = (state_q == CT_IDLE) & ~cfg_busy & ~nxt_bad;
        period_end = (state_q != CT_IDLE) & tick & (bcnt_q == SWD_B_W'(1));
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CT_IDLE;
            bcnt_q  <= '0;
            acnt_q  <= '0;
        end else begin
            state_q <= state_d;
            bcnt_q  <= bcnt_d;
            acnt_q  <= acnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        bcnt_d  = bcnt_q;
        acnt_d  = acnt_q;
        unique case (state_q)
            CT_IDLE: begin
                if (start) begin
                    state_d = (nxt_cfg.a != '0) ? CT_SWALLOW : CT_MAIN;
                    bcnt_d  = nxt_cfg.b;
                    acnt_d  = nxt_cfg.a;
                end
            end
            CT_SWALLOW, CT_MAIN: begin
                if (period_end) begin
                    if (nxt_bad) begin
                        state_d = CT_IDLE;
                    end else begin
                        state_d = (nxt_cfg.a != '0) ? CT_SWALLOW : CT_MAIN;
                        bcnt_d  = nxt_cfg.b;
                        acnt_d  = nxt_cfg.a;
                    end
                end else if (tick) begin
                    bcnt_d = bcnt_q - 1'b1;
                    if (state_q == CT_SWALLOW) begin
                        acnt_d  = acnt_q - 1'b1;
                        state_d = (acnt_q == SWD_A_W'(1)) ? CT_MAIN : CT_SWALLOW;
                    end
                end
            end
            default: state_d = CT_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) div_q <= 1'b0;
        else     div_q <= period_end;
    end

    always_comb begin
        run      = (state_q != CT_IDLE);
        idle     = (state_q == CT_IDLE);
        mod      = (state_q == CT_SWALLOW);
        boundary = period_end;
        div_out  = div_q;
    end

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        div_q |=> !div_q);
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == CT_IDLE) |=> !div_q);
    assert_swallow_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == CT_SWALLOW) |-> (SWD_B_W'(acnt_q) <= bcnt_q));
endmodule

// File: rtl/swallow_fb_divider.sv
module swallow_fb_divider
    import swdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SWD_SEL_W-1:0] psel,
    input  logic [SWD_B_W-1:0]   b_val,
    input  logic [SWD_A_W-1:0]   a_val,
    input  logic                 load,
    output logic                 div_out,
    output logic                 cfg_bad
);
    swdiv_cfg_t in_cfg;
    swdiv_cfg_t act_cfg;
    swdiv_cfg_t nxt_cfg;
    logic       act_bad;
    logic       nxt_bad;
    logic       busy;
    logic       run;
    logic       mod;
    logic       idle;
    logic       boundary;
    logic       tick;

    always_comb begin
        in_cfg.sel = psel;
        in_cfg.b   = b_val;
        in_cfg.a   = a_val;
    end

    swdiv_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .in_cfg   (in_cfg),
        .idle     (idle),
        .boundary (boundary),
        .act_cfg  (act_cfg),
        .nxt_cfg  (nxt_cfg),
        .busy     (busy)
    );

    swdiv_cfg_check u_chk_act (.cfg(act_cfg), .bad(act_bad));
    swdiv_cfg_check u_chk_nxt (.cfg(nxt_cfg), .bad(nxt_bad));

    swdiv_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sel  (act_cfg.sel),
        .mod  (mod),
        .tick (tick)
    );

    swdiv_count_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .nxt_cfg  (nxt_cfg),
        .nxt_bad  (nxt_bad),
        .cfg_busy (busy),
        .run      (run),
        .mod      (mod),
        .idle     (idle),
        .boundary (boundary),
        .div_out  (div_out)
    );

    assign cfg_bad = act_bad;

    assert_run_cfg_ok_R5: assert property (@(posedge clk) disable iff (rst)
        run |-> !act_bad);
endmodule

// File: tb/swallow_fb_divider_bench.sv
module swallow_fb_divider_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  psel = '0;
    logic [12:0] b_val = '0;
    logic [5:0]  a_val = '0;
    logic        load = 1'b0;
    logic        div_out;
    logic        cfg_bad;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string cur_req = "R9";
    bit   cmp_on = 1'b0;

    swallow_fb_divider u_swallow_fb_divider (
        .clk(clk), .rst(rst), .psel(psel), .b_val(b_val), .a_val(a_val),
        .load(load), .div_out(div_out), .cfg_bad(cfg_bad)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model state
    int m_as = 0, m_ab = 0, m_aa = 0;
    int m_ps = 0, m_pb = 0, m_pa = 0;
    bit m_pflag = 0, m_run = 0, m_out = 0, m_bad = 1;
    int m_cnt = 0;

    function automatic bit m_good(int s, int b, int a);
        int p = 8 << s;
        return (b >= 3) && (a <= b) && ((b * p + a) >= (p * p - p));
    endfunction

    function automatic int m_n(int s, int b, int a);
        return b * (8 << s) + a;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_as = 0; m_ab = 0; m_aa = 0; m_pflag = 0; m_run = 0; m_out = 0; m_cnt = 0;
        end else begin
            bit bnd;
            bnd = m_run && (m_cnt == 1);
            m_out = bnd;
            if (m_run) begin
                if (bnd) begin
                    if (m_pflag) begin m_as = m_ps; m_ab = m_pb; m_aa = m_pa; m_pflag = 0; end
                    if (m_good(m_as, m_ab, m_aa)) m_cnt = m_n(m_as, m_ab, m_aa);
                    else m_run = 0;
                end else begin
                    m_cnt--;
                end
                if (load) begin m_ps = psel; m_pb = b_val; m_pa = a_val; m_pflag = 1; end
            end else begin
                if (load) begin m_as = psel; m_ab = b_val; m_aa = a_val; m_pflag = 0; end
                else if (m_pflag) begin m_as = m_ps; m_ab = m_pb; m_aa = m_pa; m_pflag = 0; end
                else if (m_good(m_as, m_ab, m_aa)) begin m_run = 1; m_cnt = m_n(m_as, m_ab, m_aa); end
            end
        end
        m_bad = !m_good(m_as, m_ab, m_aa);
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            checks++;
            if (div_out !== m_out || cfg_bad !== m_bad) begin
                fails++;
                $display("FAIL %s model cycle %0d: actual out=%0b bad=%0b expected out=%0b bad=%0b",
                         cur_req, cyc, div_out, cfg_bad, m_out, m_bad);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic apply(int s, int b, int a);
        @(negedge clk);
        psel = 2'(s); b_val = 13'(b); a_val = 6'(a); load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_pulse(string req, output int t);
        int waited = 0;
        t = -1;
        while (waited < 20000) begin
            @(negedge clk);
            if (div_out) begin t = cyc; return; end
            waited++;
        end
        check(req, "pulse timeout", 0, 1);
    endtask

    task automatic gap_check(string req, int s, int b, int a);
        int t0, t1, t2;
        cur_req = req;
        apply(s, b, a);
        wait_pulse(req, t0);
        wait_pulse(req, t1);
        wait_pulse(req, t2);
        check(req, "pulse spacing", t2 - t1, b * (8 << s) + a);
    endtask

    task automatic quiet_check(string req, int s, int b, int a);
        int t0, seen;
        cur_req = req;
        apply(s, b, a);
        wait_pulse(req, t0);     // last pulse of the running legal period (R10)
        @(negedge clk);
        check(req, "cfg_bad after invalid boundary", int'(cfg_bad), 1);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (div_out) seen++;
        end
        check(req, "pulses while invalid", seen, 0);
    endtask

    initial begin
        int t0, t1, t2, t3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9", "div_out after reset", int'(div_out), 0);
        check("R9", "cfg_bad after reset", int'(cfg_bad), 1);

        // R9/R1: first pulse from idle lands N+2 cycles after the load cycle
        cur_req = "R1";
        @(negedge clk);
        psel = 2'd0; b_val = 13'd7; a_val = 6'd3; load = 1'b1;
        t0 = cyc;
        @(negedge clk);
        load = 1'b0;
        wait_pulse("R1", t1);
        check("R1", "first pulse delay from idle", t1 - t0, 59 + 2);
        wait_pulse("R1", t2);
        check("R1", "spacing P=8 B=7 A=3", t2 - t1, 59);

        // R6: A = 0 divides by P only; R2 modulus 16
        gap_check("R6", 1, 20, 0);
        // R2: moduli 32 and 64
        gap_check("R2", 2, 40, 17);
        gap_check("R2", 3, 70, 63);
        // R1: A equal to B
        gap_check("R1", 0, 8, 8);
        // R5: exactly P^2-P is legal (P=16, B=15, A=0 -> 240)
        gap_check("R5", 1, 15, 0);

        // R1: random legal settings
        for (int k = 0; k < 6; k++) begin
            int s, p, b, a, amax;
            s = $urandom_range(0, 2);
            p = 8 << s;
            b = $urandom_range(p - 1, p + 20);
            amax = (b < 63) ? b : 63;
            a = $urandom_range(0, amax);
            gap_check("R1", s, b, a);
        end

        // R7: load mid-period defers to the next boundary, newest staged wins
        cur_req = "R7";
        gap_check("R7", 0, 9, 2);              // N = 74, now running
        wait_pulse("R7", t0);
        repeat (10) @(negedge clk);
        apply(0, 12, 0);                        // staged, then superseded
        apply(0, 11, 5);                        // N = 93
        wait_pulse("R7", t1);
        check("R7", "period in flight unchanged", t1 - t0, 74);
        wait_pulse("R7", t2);
        check("R7", "newest staged setting applied", t2 - t1, 93);
        wait_pulse("R7", t3);
        check("R7", "new setting persists", t3 - t2, 93);

        // R3: B below 3; R10 last pulse then quiet
        quiet_check("R3", 0, 2, 0);
        gap_check("R10", 0, 10, 1);
        // R4: A greater than B
        quiet_check("R4", 0, 9, 10);
        gap_check("R9", 0, 7, 0);
        // R5: just below P^2-P (P=16, B=14 -> 224)
        quiet_check("R5", 1, 14, 0);
        gap_check("R5", 3, 64, 0);
        quiet_check("R5", 3, 50, 0);

        // R8: no two adjacent high cycles over a legal run
        cur_req = "R8";
        apply(0, 7, 0);
        t0 = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (div_out) begin
                @(negedge clk);
                if (div_out) t0++;
            end
        end
        check("R8", "adjacent high cycles", t0, 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule